// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pullups

This block is an 8-bit general-purpose I/O port for a small microcontroller. Software reaches it through a simple byte-wide register bus. There are three registers: an output latch, a direction mask and a pullup mask. For every pin the block drives three signals toward the pad: an output enable, an output level and a pullup request. Each pin's incoming level passes through a two-flop synchronizer before any read path sees it.

A read of the data register is assembled one bit at a time. Bits whose direction is set to output return the value held in the output latch. Bits set to input return the synchronized pad level. A pin's pullup request can only be active while that pin is an input, so the output driver and the pullup are never on together. Writes to the latch are always accepted, whatever the direction setting. This lets software preload a level before it turns a pin into an output.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted, the latch, the direction mask and the pullup mask are all zero. As a result pin_oe, pin_out and pin_pu are 0x00, and reads of offsets 0x7 and 0xB return 0x00.
- R2: A write to offset 0x3 loads the output latch whatever the direction mask holds. From the next clock, pin_out equals the written byte.
- R3: The direction mask sits at offset 0x7 and can be read and written. pin_oe bit i is 1 exactly when direction bit i is 1, so a 1 means output.
- R4: The pullup mask sits at offset 0xB and can be read and written. A read returns the last value written.
- R5: pin_pu bit i is 1 only when pullup bit i is 1 and direction bit i is 0. While a pin is an output, its pullup bit has no effect on pin_pu.
- R6: A read of offset 0x3 returns, in each bit whose direction bit is 1, that bit of the output latch.
- R7: A read of offset 0x3 returns, in each bit whose direction bit is 0, the value pin_in had two clock edges earlier, because of the two-stage synchronizer.
- R8: A read of any offset other than 0x3, 0x7 or 0xB returns 0x00. A write to such an offset changes none of the three registers.
- R9: Writing the latch while a bit is an input leaves the value read back for that bit equal to the pin level. Once the bit is switched to output, the written latch value is read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register offset within the port window |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| pin_in | input | 8 | Asynchronous pad input levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output level |
| pin_pu | output | 8 | Per-pin pullup request |

## Verification
The bench sweeps all 256 direction masks against several latch and pin patterns and checks the per-bit read mix. A design that chose the read source for the whole byte, or that inverted the select, would return latch bits where pin bits belong. The bench also sweeps the pullup mask against direction masks, which exposes any design that leaves the pullup on for an output pin. A pin edge is followed clock by clock to show that the read changes after exactly the second edge and not after the first. Writes to every unmapped offset are checked to disturb nothing and to read back as zero. A design with a loose address decode would alias them onto a real register.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // Which register a bus offset selects.
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_DIR  = 2'd2,
      SEL_PUE  = 2'd3
   } gpio_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= '0;
         end else if (s == 0) begin
            stage_q[s] <= async_in;
         end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_port_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter int ADDR_W   = 4,
   parameter int DATA_OFS = 3,
   parameter int DIR_OFS  = 7,
   parameter int PUE_OFS  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [WIDTH-1:0]  wdata,
   output gpio_sel_e         sel,
   output logic [WIDTH-1:0]  latch_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  pue_q
);

   localparam int WINDOW = 1 << ADDR_W;

   if (DATA_OFS >= WINDOW || DIR_OFS >= WINDOW || PUE_OFS >= WINDOW) begin : g_bad_ofs
      $error("gpio_regfile: register offset outside address window");
   end
   if (DATA_OFS == DIR_OFS || DATA_OFS == PUE_OFS || DIR_OFS == PUE_OFS) begin : g_dup_ofs
      $error("gpio_regfile: register offsets must be distinct");
   end

   always_comb begin
      if (addr == ADDR_W'(DATA_OFS))      sel = SEL_DATA;
      else if (addr == ADDR_W'(DIR_OFS))  sel = SEL_DIR;
      else if (addr == ADDR_W'(PUE_OFS))  sel = SEL_PUE;
      else                                sel = SEL_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
         pue_q   <= '0;
      end else if (wr) begin
         case (sel)
            SEL_DATA: latch_q <= wdata;
            SEL_DIR:  dir_q   <= wdata;
            SEL_PUE:  pue_q   <= wdata;
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] pue_q,
   input  logic [WIDTH-1:0] pin_sync,
   output logic [WIDTH-1:0] oe,
   output logic [WIDTH-1:0] out,
   output logic [WIDTH-1:0] pu,
   output logic [WIDTH-1:0] data_rd
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign oe[i]      = dir_q[i];
      assign out[i]     = latch_q[i];
      assign pu[i]      = pue_q[i] & ~dir_q[i];
      assign data_rd[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
   end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int ADDR_W      = 4,
   parameter int DATA_OFS    = 3,
   parameter int DIR_OFS     = 7,
   parameter int PUE_OFS     = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic [NUM_PINS-1:0] reg_wdata,
   output logic [NUM_PINS-1:0] reg_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_pu
);

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("gpio_port: NUM_PINS must be positive");
   end

   gpio_sel_e           sel;
   logic [NUM_PINS-1:0] latch_q, dir_q, pue_q, pin_sync, data_rd;

   gpio_regfile #(
      .WIDTH(NUM_PINS), .ADDR_W(ADDR_W),
      .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS), .PUE_OFS(PUE_OFS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
      .sel(sel), .latch_q(latch_q), .dir_q(dir_q), .pue_q(pue_q)
   );

   gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
   );

   gpio_pin_ctrl #(.WIDTH(NUM_PINS)) u_pins (
      .latch_q(latch_q), .dir_q(dir_q), .pue_q(pue_q), .pin_sync(pin_sync),
      .oe(pin_oe), .out(pin_out), .pu(pin_pu), .data_rd(data_rd)
   );

   always_comb begin
      case (sel)
         SEL_DATA: reg_rdata = data_rd;
         SEL_DIR:  reg_rdata = dir_q;
         SEL_PUE:  reg_rdata = pue_q;
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int NUM_PINS    = 8,
   parameter int ADDR_W      = 4,
   parameter int DATA_OFS    = 3,
   parameter int DIR_OFS     = 7,
   parameter int PUE_OFS     = 11,
   parameter int SYNC_STAGES = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic                reg_wr,
   input logic [NUM_PINS-1:0] reg_wdata,
   input logic [NUM_PINS-1:0] reg_rdata,
   input logic [NUM_PINS-1:0] pin_in,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_pu
);

   logic [1:0] since_rst;
   logic       at_data, unmapped;

   assign at_data  = (reg_addr == ADDR_W'(DATA_OFS));
   assign unmapped = !at_data && reg_addr != ADDR_W'(DIR_OFS) && reg_addr != ADDR_W'(PUE_OFS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (pin_oe == '0 && pin_out == '0 && pin_pu == '0); // R1
      end
   end

   AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && at_data) |=> (pin_out == $past(reg_wdata))); // R2

   AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(DIR_OFS)) |=> (pin_oe == $past(reg_wdata))); // R3

   AST_NO_PULL_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_pu & pin_oe) == '0)); // R5

   AST_OUTPUT_BITS_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      at_data |-> (((reg_rdata ^ pin_out) & pin_oe) == '0)); // R6

   if (SYNC_STAGES == 2) begin : g_sync_chk
      AST_INPUT_BITS_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 2'd2 && at_data) |-> (((reg_rdata ^ $past(pin_in, 2)) & ~pin_oe) == '0)); // R7
   end

   AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> (reg_rdata == '0)); // R8

   AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && unmapped) |=> ($stable(pin_oe) && $stable(pin_out) && $stable(pin_pu))); // R8

endmodule

bind gpio_port gpio_port_chk #(
   .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS),
   .DIR_OFS(DIR_OFS), .PUE_OFS(PUE_OFS), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
   .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;

   localparam logic [3:0] A_DATA = 4'h3;
   localparam logic [3:0] A_DIR  = 4'h7;
   localparam logic [3:0] A_PUE  = 4'hB;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_oe, pin_out, pin_pu;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   gpio_port uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   initial begin
      logic [7:0] v;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 oe", pin_oe, 8'h00);
      check("R1 out", pin_out, 8'h00);
      check("R1 pu", pin_pu, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      rd_reg(A_DIR, v);  check("R1 dir read", v, 8'h00);
      rd_reg(A_PUE, v);  check("R1 pue read", v, 8'h00);
      rd_reg(A_DATA, v); check("R1 data read", v, 8'h00);

      // R2 R3 R6 R7: sweep every direction mask against latch/pin patterns
      for (int d = 0; d < 256; d++) begin
         for (int k = 0; k < 3; k++) begin
            logic [7:0] lat, pin;
            lat = 8'((d * 37 + k * 91 + 5) & 8'hFF);
            pin = 8'((d * 113 + k * 59 + 200) & 8'hFF);
            wr_reg(A_DIR, 8'(d));
            wr_reg(A_DATA, lat);
            pin_in = pin;
            repeat (2) @(negedge clk);
            check("R3 oe", pin_oe, 8'(d));
            check("R2 out", pin_out, lat);
            rd_reg(A_DATA, v);
            check("R6/R7 data mix", v, (lat & 8'(d)) | (pin & ~8'(d)));
         end
         rd_reg(A_DIR, v);
         check("R3 dir read", v, 8'(d));
      end

      // R4 R5: sweep pullup masks against direction masks
      for (int p = 0; p < 256; p++) begin
         logic [7:0] dm;
         dm = 8'((p * 29 + 17) & 8'hFF);
         wr_reg(A_PUE, 8'(p));
         wr_reg(A_DIR, dm);
         @(negedge clk);
         rd_reg(A_PUE, v);
         check("R4 pue read", v, 8'(p));
         check("R5 pu gating", pin_pu, 8'(p) & ~dm);
      end

      // R8: unmapped offsets
      wr_reg(A_DATA, 8'h3C);
      wr_reg(A_DIR, 8'hA5);
      wr_reg(A_PUE, 8'h66);
      for (int a = 0; a < 16; a++) begin
         if (a != 3 && a != 7 && a != 11) begin
            wr_reg(4'(a), 8'hFF);
            rd_reg(4'(a), v);
            check("R8 unmapped read", v, 8'h00);
            check("R8 latch kept", pin_out, 8'h3C);
            check("R8 oe kept", pin_oe, 8'hA5);
            check("R8 pu kept", pin_pu, 8'h66 & ~8'hA5);
         end
      end
      rd_reg(A_PUE, v); check("R8 pue kept", v, 8'h66);

      // R9: latch write while input, then switch to output
      wr_reg(A_DIR, 8'h00);
      pin_in = 8'h5A;
      repeat (2) @(negedge clk);
      wr_reg(A_DATA, 8'hFF);
      rd_reg(A_DATA, v); check("R9 input read keeps pin", v, 8'h5A);
      wr_reg(A_DIR, 8'hFF);
      rd_reg(A_DATA, v); check("R9 output read shows latch", v, 8'hFF);

      // R7: exact two-edge delay
      wr_reg(A_DIR, 8'h00);
      pin_in = 8'h00;
      repeat (3) @(negedge clk);
      reg_addr = A_DATA;
      pin_in = 8'hC3;
      @(negedge clk);
      rd_reg(A_DATA, v); check("R7 after one edge", v, 8'h00);
      @(negedge clk);
      rd_reg(A_DATA, v); check("R7 after two edges", v, 8'hC3);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule